// File: doc/BRIEF.md
# Keyed Shutdown Controller with Wake Qualification

This always-on block lives in the slow-clock domain and removes main power on request. Software writes a shutdown request over a small 32-bit register bus. The request only takes effect when it carries the right password byte. The block then raises its shutdown output and keeps it high until an enabled wake source fires.

There are three wake sources. The first is an external wake pin, qualified by a selectable level condition and a debounce count. The other two are event pulses from a real-time timer and from a real-time clock, and each has its own enable. Every event that ends a shutdown is recorded in a status register. Reading that register clears it. An all-zero status after power-up therefore means a plain cold start.

Top module: `pwr_cut_ctrl`

## Requirements
- R1: After a synchronous active-low reset the following hold:
  - `shdn_out` is 0.
  - The mode register reads 0x0000_0003: either-level pin wake, debounce 0, both timer enables cleared.
  - The status register reads 0.
- R2: A write to offset 0x00 starts a shutdown when bit 0 is 1 and bits 31:24 equal 0xA5. `shdn_out` is 1 from the cycle after that write.
- R3: A write to offset 0x00 is ignored when bit 0 is 0 or when bits 31:24 are anything other than 0xA5. `shdn_out` stays 0.
- R4: The mode register at offset 0x04 holds these fields:
  - bits 2:0: pin mode.
  - bits 7:4: debounce count.
  - bit 16: timer wake enable.
  - bit 17: clock wake enable.

  All other mode bits read 0. Offset 0x00 reads 0, and any offset other than 0x04 and 0x08 reads 0. `bus_rdata` is 0 when `bus_rd` is low.
- R5: The pin mode selects the pin condition:
  - 1: the pin is high.
  - 2: the pin is low.
  - 3: the pin differs from the level it had on the cycle the shutdown request was accepted.
  - 0 and 4 to 7: the pin never wakes the block.
- R6: The pin wakes the block only after the condition has held for (debounce count + 1) consecutive cycles of shutdown. Any cycle without the condition restarts the count.
- R7: A pulse on `rtt_evt` wakes the block only when mode bit 16 is 1. A pulse on `rtc_evt` wakes it only when mode bit 17 is 1.
- R8: A qualified wake event that is sampled at a clock edge while shut down clears `shdn_out` at that edge. The block is then running and accepts a new keyed request.
- R9: Status bit 0 records a pin wake, bit 16 a timer wake and bit 17 a clock wake. Bits are set only by qualified events during shutdown, and all events of the same cycle are recorded. Events while running leave the status unchanged.
- R10: A read of offset 0x08 returns the status and clears it at that edge. A wake recorded at the same edge survives the clear.
- R11: A keyed write during shutdown changes nothing. The mode register may be rewritten during shutdown, and the new settings apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while `bus_rd` is high |
| wake_pin | input | 1 | External wake pin, already synchronous to `clk` |
| rtt_evt | input | 1 | Real-time timer wake pulse |
| rtc_evt | input | 1 | Real-time clock wake pulse |
| shdn_out | output | 1 | High while main power is to be removed |

## Verification
The assertions assume the following about the inputs:
- `wake_pin`, `rtt_evt` and `rtc_evt` are already synchronous to `clk`.
- `bus_wr` and `bus_rd` are single-cycle strobes that are never high together.
- Each strobe comes with a stable address and data.

The stimulus keeps to these assumptions. It drives every input just after the falling edge and raises exactly one strobe per access. The wake inputs are changed only between edges, in patterns that probe the debounce count: a break one cycle short of the limit, exact-limit runs, and timer pulses that arrive with their enables both off and on.

// File: rtl/pwr_cut_pkg.sv
// Package: register offsets, key value, pin-mode encoding and the mode
// register layout shared by the shutdown controller modules.
package pwr_cut_pkg;
    localparam int CNT_W = 4;                  // debounce count field width
    localparam logic [7:0] REG_CTRL = 8'h00;
    localparam logic [7:0] REG_MODE = 8'h04;
    localparam logic [7:0] REG_STAT = 8'h08;
    localparam logic [7:0] CUT_KEY  = 8'hA5;

    typedef enum logic [2:0] {
        PM_OFF  = 3'd0,
        PM_HIGH = 3'd1,
        PM_LOW  = 3'd2,
        PM_EDGE = 3'd3
    } pin_mode_e;

    typedef struct packed {
        logic             clk_en;
        logic             tmr_en;
        logic [CNT_W-1:0] dbn;
        logic [2:0]       pmode;
    } mode_cfg_t;

    localparam mode_cfg_t MODE_RST = '{clk_en: 1'b0, tmr_en: 1'b0,
                                       dbn: '0, pmode: 3'(PM_EDGE)};
endpackage

// File: rtl/pwr_pin_qual.sv
// Wake-pin qualifier. Raises pin_wake when the selected pin condition has
// held for (limit + 1) consecutive cycles while armed.
// Assumes: pin is already synchronous to clk; ref_lvl is stable while armed.
module pwr_pin_qual
    import pwr_cut_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic [2:0]   pmode,
    input  logic [W-1:0] limit,
    input  logic         pin,
    input  logic         ref_lvl,
    output logic         pin_wake
);
    logic         cond;
    logic         hit;
    logic [W-1:0] run;

    // Decode the pin condition selected by the mode field.
    always_comb begin
        case (pmode)
            3'(PM_HIGH): cond = pin;
            3'(PM_LOW):  cond = ~pin;
            3'(PM_EDGE): cond = (pin != ref_lvl);
            default:     cond = 1'b0;
        endcase
    end

    assign hit      = armed & cond;
    assign pin_wake = hit & (run >= limit);

    // Count consecutive qualifying cycles; any break or a wake restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)                run <= '0;
        else if (hit && !pin_wake) run <= run + 1'b1;
        else                       run <= '0;
    end

    // R6: a nonzero run count implies the previous cycle qualified.
    a_r6_run_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (run != '0) |-> $past(hit));
endmodule

// File: rtl/pwr_cut_core.sv
// Shutdown state and wake status. It enters shutdown on start and leaves on
// any qualified wake, and it records the wake sources of that edge.
// Assumes: start and clr_stat are single-cycle strobes from the register decode.
module pwr_cut_core (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       pin_wake,
    input  logic       tmr_evt,
    input  logic       clk_evt,
    input  logic       tmr_en,
    input  logic       clk_en,
    input  logic       clr_stat,
    output logic       down,
    output logic [2:0] stat
);
    logic [2:0] ev;
    logic       wake_any;

    assign ev       = down ? {clk_en & clk_evt, tmr_en & tmr_evt, pin_wake} : 3'b000;
    assign wake_any = |ev;

    // Shutdown state: wake has priority while down; start only acts while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                 down <= 1'b0;
        else if (down && wake_any)  down <= 1'b0;
        else if (!down && start)    down <= 1'b1;
    end

    // Status: clear on read, then merge the wake events of this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (clr_stat ? 3'b000 : stat) | ev;
    end

    // R2: an accepted request while running leads to shutdown next cycle.
    a_r2_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (!down && start) |=> down);
    // R8: a qualified wake while down returns the block to running.
    a_r8_wake_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (down && wake_any) |=> !down);
    // R9: no new status bit appears from a cycle spent running.
    a_r9_no_stat_when_up: assert property (@(posedge clk) disable iff (!rst_n)
        !down |=> ((stat & ~$past(stat)) == 3'b000));
endmodule

// File: rtl/pwr_cut_ctrl.sv
// Top of the keyed shutdown controller. Decodes the register bus, holds the
// mode register and the pin reference level, and drives the read mux.
// Assumes: bus_wr and bus_rd are never high together; all inputs synchronous.
module pwr_cut_ctrl
    import pwr_cut_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wake_pin,
    input  logic              rtt_evt,
    input  logic              rtc_evt,
    output logic              shdn_out
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(REG_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

    mode_cfg_t  mode_q;
    logic       ref_q;
    logic       wr_ctrl;
    logic       key_ok;
    logic       start;
    logic       clr_stat;
    logic       down;
    logic       pin_wake;
    logic [2:0] stat;

    assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
    assign key_ok   = (bus_wdata[31:24] == CUT_KEY) & bus_wdata[0];
    assign start    = wr_ctrl & key_ok;
    assign clr_stat = bus_rd & (bus_addr == A_STAT);
    assign shdn_out = down;

    // Mode register: written at any time, takes effect next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_RST;
        else if (bus_wr && bus_addr == A_MODE)
            mode_q <= '{clk_en: bus_wdata[17], tmr_en: bus_wdata[16],
                        dbn: bus_wdata[7:4], pmode: bus_wdata[2:0]};
    end

    // Pin reference: level seen when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)              ref_q <= 1'b0;
        else if (start && !down) ref_q <= wake_pin;
    end

    // Read mux: control reads zero, unused bits and offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_MODE)
                bus_rdata = {14'b0, mode_q.clk_en, mode_q.tmr_en, 8'b0,
                             mode_q.dbn, 1'b0, mode_q.pmode};
            else if (bus_addr == A_STAT)
                bus_rdata = {14'b0, stat[2], stat[1], 15'b0, stat[0]};
        end
    end

    pwr_pin_qual #(.W(CNT_W)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (down),
        .pmode    (mode_q.pmode),
        .limit    (mode_q.dbn),
        .pin      (wake_pin),
        .ref_lvl  (ref_q),
        .pin_wake (pin_wake)
    );

    pwr_cut_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pin_wake (pin_wake),
        .tmr_evt  (rtt_evt),
        .clk_evt  (rtc_evt),
        .tmr_en   (mode_q.tmr_en),
        .clk_en   (mode_q.clk_en),
        .clr_stat (clr_stat),
        .down     (down),
        .stat     (stat)
    );

    // R3: a control write with a bad key or bit 0 clear leaves the block running.
    a_r3_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_out && wr_ctrl && !key_ok) |=> !shdn_out);
    // R11: a keyed write during shutdown with no wake leaves shutdown in force.
    a_r11_rekey_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_out && start && !pin_wake && !rtt_evt && !rtc_evt) |=> shdn_out);
endmodule

// File: tb/pwr_cut_ctrl_tb.sv
module pwr_cut_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wake_pin = 1'b0, rtt_evt = 1'b0, rtc_evt = 1'b0;
    logic        shdn_out;

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit          m_off, m_ref, m_tmr, m_clk;
    int          m_pm, m_lim, m_run;
    logic [31:0] m_stat;

    always #10 clk = ~clk;

    pwr_cut_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_pin(wake_pin), .rtt_evt(rtt_evt), .rtc_evt(rtc_evt),
        .shdn_out(shdn_out)
    );

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        if (!bus_rd) return 32'h0;
        if (bus_addr == 8'h04)
            return (32'(m_clk) << 17) | (32'(m_tmr) << 16) | 32'(m_lim << 4) | 32'(m_pm);
        if (bus_addr == 8'h08) return m_stat;
        return 32'h0;
    endfunction

    // Reference update for one rising edge, using the inputs held across it.
    task automatic model_edge();
        bit old_off, cond, hit, pw;
        logic [31:0] evb;
        if (!rst_n) begin
            m_off = 0; m_ref = 0; m_tmr = 0; m_clk = 0;
            m_pm = 3; m_lim = 0; m_run = 0; m_stat = 0;
            return;
        end
        old_off = m_off;
        case (m_pm)
            1: cond = wake_pin;
            2: cond = !wake_pin;
            3: cond = (wake_pin != m_ref);
            default: cond = 0;
        endcase
        hit = old_off && cond;
        pw  = hit && (m_run >= m_lim);
        evb = 0;
        if (old_off) begin
            if (pw) evb[0] = 1;
            if (m_tmr && rtt_evt) evb[16] = 1;
            if (m_clk && rtc_evt) evb[17] = 1;
        end
        m_stat = ((bus_rd && bus_addr == 8'h08) ? 32'h0 : m_stat) | evb;
        m_run  = (hit && !pw) ? m_run + 1 : 0;
        if (old_off && evb != 0) m_off = 0;
        else if (!old_off && bus_wr && bus_addr == 8'h00 &&
                 bus_wdata[31:24] == 8'hA5 && bus_wdata[0]) begin
            m_off = 1; m_ref = wake_pin;
        end
        if (bus_wr && bus_addr == 8'h04) begin
            m_pm  = int'(bus_wdata[2:0]); m_lim = int'(bus_wdata[7:4]);
            m_tmr = bus_wdata[16];        m_clk = bus_wdata[17];
        end
    endtask

    // One cycle: check read data before the edge, shdn_out after it.
    task automatic tick();
        #1;
        if (bus_rd) check("rdata", bus_rdata, exp_rd());
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("shdn_out", 32'(shdn_out), 32'(m_off));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a);
        bus_rd = 1; bus_addr = a;
        tick();
        bus_rd = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset values
        cur_req = "R1";
        idle(3);
        rst_n = 1;
        idle(1);
        rd(8'h04); rd(8'h08);

        // R4: field layout, unused bits, write-only control, unknown offset
        cur_req = "R4";
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);
        rd(8'h00); rd(8'h0C);
        bus_addr = 8'h04; tick();          // no strobe: rdata must be 0
        check("rdata idle", bus_rdata, 32'h0);

        // R3: bad key, and good key with bit 0 clear
        cur_req = "R3";
        wr(8'h04, 32'h0000_0031);          // high level, debounce 3
        wr(8'h00, 32'h5A00_0001); idle(2);
        wr(8'h00, 32'hA500_0000); idle(2);
        wr(8'h00, 32'hA400_0001); idle(1);

        // R2 R5 R6: high-level wake with debounce 3, glitch restarts count
        cur_req = "R2";
        wake_pin = 0;
        wr(8'h00, 32'hA500_0001);
        cur_req = "R6";
        wake_pin = 1; idle(3);             // one short of four
        wake_pin = 0; idle(1);
        wake_pin = 1; idle(3);
        check("still down", 32'(shdn_out), 32'h1);
        cur_req = "R8";
        idle(1);                           // fourth qualifying cycle wakes
        check("released", 32'(shdn_out), 32'h0);
        cur_req = "R10";
        rd(8'h08); rd(8'h08);

        // R5: low-level wake, debounce 0
        cur_req = "R5";
        wr(8'h04, 32'h0000_0002);
        wake_pin = 1;
        wr(8'h00, 32'hA500_0001); idle(2);
        wake_pin = 0; idle(2);
        rd(8'h08);

        // R5: level-change wake relative to entry level
        wr(8'h04, 32'h0000_0013);
        wake_pin = 1;
        wr(8'h00, 32'hA500_0001); idle(3);
        wake_pin = 0; idle(1);             // one matching cycle, limit 1
        wake_pin = 1; idle(1);
        wake_pin = 0; idle(3);
        rd(8'h08);

        // R5 R7: no-pin modes, disabled timer ignored, then enabled timer
        wr(8'h04, 32'h0000_0005);
        wr(8'h00, 32'hA500_0001);
        for (int i = 0; i < 6; i++) begin wake_pin = ~wake_pin; idle(1); end
        cur_req = "R7";
        rtt_evt = 1; rtc_evt = 1; idle(1); rtt_evt = 0; rtc_evt = 0;
        check("disabled events", 32'(shdn_out), 32'h1);
        cur_req = "R11";
        wr(8'h04, 32'h0001_0000);          // timer enable, pin off, during shutdown
        wr(8'h00, 32'hA500_0001); idle(1);
        cur_req = "R7";
        rtt_evt = 1; idle(1); rtt_evt = 0;
        rd(8'h08);

        // R9: events while running leave the status unchanged
        cur_req = "R9";
        wr(8'h04, 32'h0003_0000);
        rtt_evt = 1; rtc_evt = 1; idle(2); rtt_evt = 0; rtc_evt = 0;
        rd(8'h08);

        // R9 R10: both timers in one cycle, together with a status read
        wr(8'h00, 32'hA500_0001); idle(1);
        cur_req = "R10";
        rtt_evt = 1; rtc_evt = 1; bus_rd = 1; bus_addr = 8'h08;
        tick();
        bus_rd = 0; rtt_evt = 0; rtc_evt = 0;
        rd(8'h08);
        check("both recorded", m_stat, 32'h0);

        // R8: block accepts a new request after a wake
        cur_req = "R8";
        wr(8'h00, 32'hA500_0001); idle(1);
        rtc_evt = 1; idle(1); rtc_evt = 0; idle(1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule